// File: doc/BRIEF.md
# Resource-Triggered Reloadable Event Counter

This block is a down-counter driven by event resources. A 32-bit control register picks two conditions. The counting condition makes the counter step down by one. The reload condition loads a programmable start value. Each condition is either one of sixteen single resource lines or one of eight combined resource pairs. The register chooses between the two kinds separately for each condition while the block runs.

A self-reload option is also available. When it is set, a counter that sits at zero reloads itself as soon as the counting condition is active. The reload condition can still trigger a reload on its own. When the option is clear, the counter stops at zero and waits for the reload condition. The resource lines and the pair combination logic sit outside this block. The block only selects among the lines it is given.

Top module: `resource_event_counter`

## Requirements
- R1: Under synchronous active-low reset, the control register reads zero, the counter value is zero and the zero flag is high.
- R2: A register write stores only the defined fields: bit 16 is the self-reload enable, bit 15 is the reload kind, bits 11:8 are the reload index, bit 7 is the count kind and bits 3:0 are the count index. Every other bit reads as zero whatever was written. The read port shows the stored value on the cycle after the write.
- R3: When the count kind bit is 0, the count index uses all four bits to select single resource line 0 to 15.
- R4: When the count kind bit is 1, only the low three bits of the count index are used, selecting combined pair 0 to 7. Bit 3 of the index has no effect.
- R5: The reload kind and reload index select the reload condition by the same rule: kind 0 selects a single line with four bits, kind 1 selects a pair with the low three bits.
- R6: When the counting condition is active, no reload occurs and the value is nonzero, the value drops by exactly one at the next clock. When the counting condition is inactive and no reload occurs, the value holds.
- R7: When the reload condition is active, the value takes the reload input at the next clock. A reload wins over a decrement in the same cycle.
- R8: When self-reload is clear, a zero value stays at zero while the counting condition stays active. It does not wrap.
- R9: When self-reload is set, a zero value together with an active counting condition loads the reload input at the next clock.
- R10: The zero flag is high exactly when the counter value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data; reserved bits read as zero |
| single_res | input | 16 | Single resource lines |
| pair_res | input | 8 | Combined resource pair lines |
| reload_value | input | 16 | Value loaded on reload |
| count_value | output | 16 | Current counter value |
| count_zero | output | 1 | High when the counter value is zero |

## Verification
A control write shows on the read port one clock after the strobe. A resource or reload input that is present before a clock edge is reflected in the counter value just after that edge. The selection uses the control value held before the edge, so a write takes effect on counting one cycle later. The zero flag follows the counter value with no extra delay. The bench drives inputs on the falling edge and advances a behavioural model at each rising edge, using the inputs and control value from before that edge. It then compares the count, the flag and the read data one time unit after every rising edge.

// File: rtl/rec_pkg.sv
// Package: control register layout and field type for the resource event counter.
// Assumes a fixed 32-bit control word with 4-bit selection indices.
package rec_pkg;
    localparam int REG_W     = 32;
    localparam int IDX_W     = 4;
    localparam int SELF_BIT  = 16;
    localparam int RKIND_BIT = 15;
    localparam int RIDX_LSB  = 8;
    localparam int CKIND_BIT = 7;
    localparam int CIDX_LSB  = 0;
    localparam logic [REG_W-1:0] DEFINED_MASK =
        (REG_W'(1) << SELF_BIT) | (REG_W'(1) << RKIND_BIT) |
        (REG_W'(4'hF) << RIDX_LSB) | (REG_W'(1) << CKIND_BIT) |
        (REG_W'(4'hF) << CIDX_LSB);

    typedef struct packed {
        logic             self_reload;
        logic             reload_pair;
        logic [IDX_W-1:0] reload_idx;
        logic             count_pair;
        logic [IDX_W-1:0] count_idx;
    } ctl_fields_t;
endpackage

// File: rtl/rec_ctl_reg.sv
// Control register: stores only the defined fields of a write and decodes them.
// Assumes a single-cycle write strobe; read data is the stored value.
module rec_ctl_reg
    import rec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output ctl_fields_t      fields
);
    logic [REG_W-1:0] ctl_q;
    logic             unused_rsvd;

    // Capture a write with reserved bits forced to zero; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= wdata & DEFINED_MASK;
    end

    // Split the stored word into named fields.
    always_comb begin
        fields.self_reload = ctl_q[SELF_BIT];
        fields.reload_pair = ctl_q[RKIND_BIT];
        fields.reload_idx  = ctl_q[RIDX_LSB +: IDX_W];
        fields.count_pair  = ctl_q[CKIND_BIT];
        fields.count_idx   = ctl_q[CIDX_LSB +: IDX_W];
    end

    assign rdata       = ctl_q;
    assign unused_rsvd = ^(ctl_q & ~DEFINED_MASK);

    assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rdata == ($past(wdata) & DEFINED_MASK));
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));
endmodule

// File: rtl/rec_res_select.sv
// Resource selector: picks one single line or one combined pair by kind and index.
// Assumes NUM_PAIR is a power of two no larger than NUM_SINGLE.
module rec_res_select #(
    parameter int NUM_SINGLE = 16,
    parameter int NUM_PAIR   = 8,
    localparam int SEL_W     = $clog2(NUM_SINGLE),
    localparam int PAIR_W    = $clog2(NUM_PAIR)
) (
    input  logic                  is_pair,
    input  logic [SEL_W-1:0]      idx,
    input  logic [NUM_SINGLE-1:0] single_res,
    input  logic [NUM_PAIR-1:0]   pair_res,
    output logic                  active
);
    // Pairs use the low index bits only; single lines use the full index.
    always_comb begin
        if (is_pair)
            active = pair_res[idx[PAIR_W-1:0]];
        else
            active = single_res[idx];
    end
endmodule

// File: rtl/rec_down_counter.sv
// Down-counter core: reload has priority, then decrement while nonzero.
// Assumes count and reload conditions are already resolved to single bits.
module rec_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_act,
    input  logic             rld_act,
    input  logic             self_en,
    input  logic [CNT_W-1:0] reload_value,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             at_zero;
    logic             do_reload;

    assign at_zero   = (cnt_q == '0);
    assign do_reload = rld_act | (self_en & cnt_act & at_zero);

    // Next value: reload wins, otherwise step down when counting and nonzero.
    always_comb begin
        cnt_d = cnt_q;
        if (do_reload)
            cnt_d = reload_value;
        else if (cnt_act && !at_zero)
            cnt_d = cnt_q - CNT_W'(1);
    end

    // Counter state register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count   = cnt_q;
    assign is_zero = at_zero;

    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld_act && cnt_act && cnt_q != '0) |=> cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1)));
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld_act && !cnt_act) |=> $stable(cnt_q));
    assert_reload_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rld_act |=> cnt_q == $past(reload_value));
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!self_en && !rld_act && cnt_q == '0) |=> cnt_q == '0);
    assert_self_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (self_en && cnt_act && cnt_q == '0) |=> cnt_q == $past(reload_value));
endmodule

// File: rtl/resource_event_counter.sv
// Top: control register, two resource selectors (count, reload) and the counter.
// Assumes resource lines are synchronous to clk; selection uses the stored control.
module resource_event_counter
    import rec_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_SINGLE = 16,
    parameter int NUM_PAIR   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic [NUM_SINGLE-1:0] single_res,
    input  logic [NUM_PAIR-1:0]   pair_res,
    input  logic [CNT_W-1:0]      reload_value,
    output logic [CNT_W-1:0]      count_value,
    output logic                  count_zero
);
    localparam int NUM_COND = 2;   // index 0: count condition, 1: reload condition

    ctl_fields_t      ctl;
    logic [NUM_COND-1:0]   cond_pair;
    logic [IDX_W-1:0]      cond_idx [NUM_COND];
    logic [NUM_COND-1:0]   cond_act;

    rec_ctl_reg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .fields (ctl)
    );

    // Route the kind and index of each condition to its selector.
    always_comb begin
        cond_pair[0] = ctl.count_pair;
        cond_idx[0]  = ctl.count_idx;
        cond_pair[1] = ctl.reload_pair;
        cond_idx[1]  = ctl.reload_idx;
    end

    for (genvar g = 0; g < NUM_COND; g++) begin : g_sel
        rec_res_select #(
            .NUM_SINGLE (NUM_SINGLE),
            .NUM_PAIR   (NUM_PAIR)
        ) u_sel (
            .is_pair    (cond_pair[g]),
            .idx        (cond_idx[g]),
            .single_res (single_res),
            .pair_res   (pair_res),
            .active     (cond_act[g])
        );
    end

    rec_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_act      (cond_act[0]),
        .rld_act      (cond_act[1]),
        .self_en      (ctl.self_reload),
        .reload_value (reload_value),
        .count        (count_value),
        .is_zero      (count_zero)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (count_value == '0 && reg_rdata == '0));
    assert_single_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.count_pair && !cond_act[1] && single_res[ctl.count_idx] && count_value != '0)
        |=> count_value == CNT_W'($past(count_value) - CNT_W'(1)));
    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count_zero == (count_value == '0));
endmodule

// File: tb/resource_event_counter_test.sv
module resource_event_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] single_res = '0;
    logic [7:0]  pair_res = '0;
    logic [15:0] reload_value = '0;
    logic [15:0] count_value;
    logic        count_zero;

    int          checks = 0;
    int          fails = 0;
    string       cur_req = "R1";
    int          m_cnt = 0;
    logic [31:0] m_ctl = '0;
    bit          done = 0;

    always #5 clk = ~clk;

    resource_event_counter uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .single_res(single_res), .pair_res(pair_res),
        .reload_value(reload_value), .count_value(count_value), .count_zero(count_zero)
    );

    // Behavioural pick: pair uses index modulo 8, single uses the full index.
    function automatic bit pick(bit is_pair, int idx);
        if (is_pair) return pair_res[idx % 8];
        return single_res[idx];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one clock using pre-edge inputs, then compare.
    task automatic step();
        bit ca;
        bit ra;
        int nc;
        logic [31:0] nctl;
        ca = pick(m_ctl[7], int'(m_ctl[3:0]));
        ra = pick(m_ctl[15], int'(m_ctl[11:8]));
        nc = m_cnt;
        if (ra || (m_ctl[16] && ca && m_cnt == 0)) nc = int'(reload_value);
        else if (ca && m_cnt > 0) nc = m_cnt - 1;
        nctl = reg_wr_en ? (reg_wdata & 32'h0001_8F8F) : m_ctl;
        if (!rst_n) begin
            nc = 0;
            nctl = '0;
        end
        @(posedge clk);
        #1;
        m_cnt = nc;
        m_ctl = nctl;
        chk(cur_req, 32'(count_value), 32'(m_cnt));
        chk("R10", 32'(count_zero), 32'(m_cnt == 0));
        chk((cur_req == "R1") ? "R1" : "R2", reg_rdata, m_ctl);
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        reg_wr_en = 1'b1;
        reg_wdata = 32'hFFFF_FFFF;
        single_res = 16'hFFFF;
        run(3);
        reg_wr_en = 1'b0;
        single_res = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2: only defined bits stored, reserved read zero
        cur_req = "R2";
        wr(32'hFFFF_FFFF);
        @(negedge clk);
        wr(32'hFFFE_7070);
        @(negedge clk);

        // R3: single count select 5, reload single 15
        cur_req = "R3";
        wr(32'h0000_0F05);
        @(negedge clk);
        reload_value = 16'd10;
        single_res = 16'h8000;
        step();
        @(negedge clk);
        single_res = 16'h0020;
        run(3);
        @(negedge clk);
        single_res = 16'h0010;
        run(2);
        @(negedge clk);
        single_res = 16'h0020;
        step();
        @(negedge clk);
        single_res = '0;

        // R4: pair count select with index 0xB -> pair 3
        cur_req = "R4";
        wr(32'h0000_0F8B);
        @(negedge clk);
        pair_res = 8'h08;
        run(2);
        @(negedge clk);
        pair_res = 8'h00;
        single_res = 16'h0800;
        run(2);
        @(negedge clk);
        single_res = '0;

        // R5: reload pair select with index 0xA -> pair 2
        cur_req = "R5";
        wr(32'h0000_8A8B);
        @(negedge clk);
        reload_value = 16'd20;
        single_res = 16'h0400;
        step();
        @(negedge clk);
        single_res = '0;
        pair_res = 8'h04;
        step();
        @(negedge clk);

        // R7: reload beats decrement
        cur_req = "R7";
        reload_value = 16'd5;
        pair_res = 8'h0C;
        step();
        @(negedge clk);

        // R8: count to zero and hold without wrap
        cur_req = "R8";
        pair_res = 8'h08;
        run(9);
        @(negedge clk);

        // R9: self-reload at zero
        cur_req = "R9";
        wr(32'h0001_8A8B);
        @(negedge clk);
        reload_value = 16'd3;
        run(10);
        @(negedge clk);

        // R6: mixed random traffic
        cur_req = "R6";
        for (int i = 0; i < 600; i++) begin
            single_res = 16'($urandom & $urandom & $urandom);
            pair_res = 8'($urandom & $urandom);
            reload_value = 16'($urandom % 40);
            if ($urandom % 25 == 0) wr($urandom);
            else step();
            @(negedge clk);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule